// File: doc/BRIEF.md
# Handshake Window Checker

This block watches a one-bit request line and a one-bit acknowledge line and reports breaks of three cycle-count rules on the handshake between them. It follows one transaction at a time. A transaction opens on the clock edge where request is first sampled high. The checker then measures how long acknowledge takes to rise, how long request stays high, and how long request takes to drop once acknowledge has risen. Every breach produces a one-cycle registered pulse and sets a flag that stays set. When the transaction is finished, a done pulse marks it and the checker goes back to idle.

Edges are found by comparing each input with a registered copy from the previous edge. A "sample" below means one rising clock edge. Sample 0 of a transaction is the edge where request is first seen high after having been low. All outputs are registered, so the result of sample k shows on the ports right after edge k.

Error vector bit order, used by both `err_pulse_o` and `err_sticky_o`: bit 0 is the late or missing acknowledge, bit 1 is a bad request high time, and bit 2 is a late or invalid request release.

Top module: `hsk_timing_mon`

## Requirements
- R1: Acknowledge must rise at one of samples 1 to 10. If it does not, bit 0 of `err_pulse_o` is high for one cycle after sample 10.
- R2: Only a low-to-high change of acknowledge counts. An acknowledge that is already high, or that rises at sample 0 together with request, does not satisfy R1.
- R3: Sample 0 counts as the first high cycle of request. If request falls after fewer than 5 high samples, bit 1 pulses after the sample where it is first seen low.
- R4: If request is still high at its 8th high sample (sample 7), bit 1 pulses after that sample.
- R5: If acknowledge rose at sample A, request must be seen low at one of samples A+1 to A+10. Bit 2 pulses after sample A+10 if it is not. Bit 2 pulses after sample A if request is already low at sample A.
- R6: A missing acknowledge cancels the release check for that transaction. The high-time check keeps running.
- R7: Each bit of `err_sticky_o` is set in the same cycle as its pulse and is cleared only by reset.
- R8: `done_o` pulses for one cycle after the first sample at which request has been seen low and every check has been decided. This can be the same cycle as the last error pulse.
- R9: A request rising edge that arrives before the checker has returned to idle is ignored.
- R10: While `rst` is high, all outputs are 0 and both edge registers clear. A request that is already high when reset drops therefore opens a transaction at the first edge after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Request line being observed |
| ack_i | input | 1 | Acknowledge line being observed |
| err_pulse_o | output | 3 | One-cycle error strobes: bit0 acknowledge, bit1 high time, bit2 release |
| err_sticky_o | output | 3 | Error flags held until reset, same bit order |
| done_o | output | 1 | One-cycle pulse when a transaction is closed |

## Verification
Three things can land on one edge: a short-hold error, a satisfied release check, and the done pulse. The bench provokes this with acknowledge at sample 2 and request falling at sample 3. It expects bit 1 and `done_o` high together in the same cycle, with bit 2 low. Two further cases also make events coincide. In the first, acknowledge rises on the very sample where request is first seen low, so the release error and done fall in one cycle. In the second, a long hold ends exactly ten samples after acknowledge, so a release that is legal on its last permitted sample closes the transaction together with the fall.

// File: rtl/hsk_timing_pkg.sv
package hsk_timing_pkg;

  localparam int RULE_ACK  = 0;
  localparam int RULE_HOLD = 1;
  localparam int RULE_REL  = 2;
  localparam int NUM_RULES = 3;

  typedef enum logic [1:0] {
    AK_IDLE,
    AK_WAIT_ACK,
    AK_WAIT_FALL,
    AK_DONE
  } ak_state_e;

  typedef enum logic [1:0] {
    HD_IDLE,
    HD_COUNT,
    HD_DONE
  } hd_state_e;

endpackage

// File: rtl/hsk_edge_det.sv
module hsk_edge_det #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] sig_i,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);

  logic [W-1:0] prev_q;

  for (genvar g = 0; g < W; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) prev_q[g] <= 1'b0;
      else     prev_q[g] <= sig_i[g];
    end
    assign rise_o[g] = sig_i[g] & ~prev_q[g];
    assign fall_o[g] = ~sig_i[g] & prev_q[g];
  end

endmodule

// File: rtl/hsk_ack_track.sv
module hsk_ack_track
  import hsk_timing_pkg::*;
#(
  parameter int CNT_W   = 4,
  parameter int ACK_MAX = 10,
  parameter int REL_MAX = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic finish_i,
  input  logic ack_rise_i,
  input  logic req_fall_i,
  input  logic req_lvl_i,
  output logic noack_o,
  output logic rel_err_o,
  output logic resolved_o
);

  localparam logic [CNT_W-1:0] ACK_LIM = CNT_W'(ACK_MAX);
  localparam logic [CNT_W-1:0] REL_LIM = CNT_W'(REL_MAX);
  localparam logic [CNT_W-1:0] SAT     = '1;

  ak_state_e        st_q, st_n;
  logic [CNT_W-1:0] cnt_q, cnt_n, cnt_inc;

  assign cnt_inc = (cnt_q == SAT) ? cnt_q : cnt_q + 1'b1;

  always_comb begin
    st_n      = st_q;
    cnt_n     = cnt_q;
    noack_o   = 1'b0;
    rel_err_o = 1'b0;
    unique case (st_q)
      AK_IDLE: begin
        if (start_i) begin
          st_n  = AK_WAIT_ACK;
          cnt_n = '0;
        end
      end
      AK_WAIT_ACK: begin
        if (ack_rise_i) begin
          if (!req_lvl_i) begin
            rel_err_o = 1'b1;
            st_n      = AK_DONE;
          end else begin
            st_n  = AK_WAIT_FALL;
            cnt_n = '0;
          end
        end else if (cnt_inc >= ACK_LIM) begin
          noack_o = 1'b1;
          st_n    = AK_DONE;
        end else begin
          cnt_n = cnt_inc;
        end
      end
      AK_WAIT_FALL: begin
        if (req_fall_i) begin
          st_n = AK_DONE;
        end else if (cnt_inc >= REL_LIM) begin
          rel_err_o = 1'b1;
          st_n      = AK_DONE;
        end else begin
          cnt_n = cnt_inc;
        end
      end
      default: st_n = AK_DONE;
    endcase
  end

  assign resolved_o = (st_n == AK_DONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= AK_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= finish_i ? AK_IDLE : st_n;
      cnt_q <= cnt_n;
    end
  end

endmodule

// File: rtl/hsk_hold_track.sv
module hsk_hold_track
  import hsk_timing_pkg::*;
#(
  parameter int CNT_W    = 4,
  parameter int HOLD_MIN = 5,
  parameter int HOLD_MAX = 7
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic finish_i,
  input  logic req_lvl_i,
  output logic hold_err_o,
  output logic resolved_o
);

  localparam logic [CNT_W-1:0] MIN_LIM = CNT_W'(HOLD_MIN);
  localparam logic [CNT_W-1:0] MAX_LIM = CNT_W'(HOLD_MAX);
  localparam logic [CNT_W-1:0] SAT     = '1;

  hd_state_e        st_q, st_n;
  logic [CNT_W-1:0] cnt_q, cnt_n, cnt_inc;

  assign cnt_inc = (cnt_q == SAT) ? cnt_q : cnt_q + 1'b1;

  always_comb begin
    st_n       = st_q;
    cnt_n      = cnt_q;
    hold_err_o = 1'b0;
    unique case (st_q)
      HD_IDLE: begin
        if (start_i) begin
          st_n  = HD_COUNT;
          cnt_n = CNT_W'(1);
        end
      end
      HD_COUNT: begin
        if (req_lvl_i) begin
          if (cnt_inc > MAX_LIM) begin
            hold_err_o = 1'b1;
            st_n       = HD_DONE;
          end else begin
            cnt_n = cnt_inc;
          end
        end else begin
          hold_err_o = (cnt_q < MIN_LIM);
          st_n       = HD_DONE;
        end
      end
      default: st_n = HD_DONE;
    endcase
  end

  assign resolved_o = (st_n == HD_DONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= HD_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= finish_i ? HD_IDLE : st_n;
      cnt_q <= cnt_n;
    end
  end

endmodule

// File: rtl/hsk_timing_mon.sv
module hsk_timing_mon
  import hsk_timing_pkg::*;
#(
  parameter int CNT_W    = 4,
  parameter int ACK_MAX  = 10,
  parameter int HOLD_MIN = 5,
  parameter int HOLD_MAX = 7,
  parameter int REL_MAX  = 10
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       req_i,
  input  logic       ack_i,
  output logic [2:0] err_pulse_o,
  output logic [2:0] err_sticky_o,
  output logic       done_o
);

  localparam int SIG_REQ = 0;
  localparam int SIG_ACK = 1;

  logic [1:0]           rise, fall;
  logic                 busy_q, fell_q, fell_n;
  logic                 start, finish;
  logic                 ak_res, hd_res;
  logic [NUM_RULES-1:0] pulse_n, pulse_q, sticky_q;

  hsk_edge_det #(.W(2)) u_edge (
    .clk    (clk),
    .rst    (rst),
    .sig_i  ({ack_i, req_i}),
    .rise_o (rise),
    .fall_o (fall)
  );

  assign start  = rise[SIG_REQ] & ~busy_q;
  assign fell_n = fell_q | fall[SIG_REQ];
  assign finish = busy_q & ak_res & hd_res & fell_n;

  hsk_ack_track #(
    .CNT_W   (CNT_W),
    .ACK_MAX (ACK_MAX),
    .REL_MAX (REL_MAX)
  ) u_ack (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start),
    .finish_i   (finish),
    .ack_rise_i (rise[SIG_ACK]),
    .req_fall_i (fall[SIG_REQ]),
    .req_lvl_i  (req_i),
    .noack_o    (pulse_n[RULE_ACK]),
    .rel_err_o  (pulse_n[RULE_REL]),
    .resolved_o (ak_res)
  );

  hsk_hold_track #(
    .CNT_W    (CNT_W),
    .HOLD_MIN (HOLD_MIN),
    .HOLD_MAX (HOLD_MAX)
  ) u_hold (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start),
    .finish_i   (finish),
    .req_lvl_i  (req_i),
    .hold_err_o (pulse_n[RULE_HOLD]),
    .resolved_o (hd_res)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q   <= 1'b0;
      fell_q   <= 1'b0;
      pulse_q  <= '0;
      sticky_q <= '0;
      done_o   <= 1'b0;
    end else begin
      if (start)       busy_q <= 1'b1;
      else if (finish) busy_q <= 1'b0;
      if (start || finish) fell_q <= 1'b0;
      else if (busy_q)     fell_q <= fell_n;
      pulse_q  <= pulse_n;
      sticky_q <= sticky_q | pulse_n;
      done_o   <= finish;
    end
  end

  assign err_pulse_o  = pulse_q;
  assign err_sticky_o = sticky_q;

endmodule

// File: rtl/hsk_timing_mon_chk.sv
module hsk_timing_mon_chk (
  input logic       clk,
  input logic       rst,
  input logic       req_i,
  input logic       ack_i,
  input logic [2:0] err_pulse_o,
  input logic [2:0] err_sticky_o,
  input logic       done_o
);

  // R7: a pulse is always mirrored in its sticky bit
  a_r7_sticky_set: assert property (@(posedge clk) disable iff (rst)
    (err_pulse_o != 3'b000) |-> ((err_sticky_o & err_pulse_o) == err_pulse_o));

  // R7: sticky bits never clear outside reset
  a_r7_sticky_keep: assert property (@(posedge clk) disable iff (rst)
    (err_sticky_o != 3'b000) |=> ((err_sticky_o & $past(err_sticky_o)) == $past(err_sticky_o)));

  // R8: done lasts one cycle
  a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R6: a missing acknowledge never comes with a release error
  a_r6_noack_no_rel: assert property (@(posedge clk) disable iff (rst)
    err_pulse_o[0] |-> !err_pulse_o[2]);

  // R1: no missing-acknowledge report right after an acknowledge edge
  a_r1_noack_no_edge: assert property (@(posedge clk) disable iff (rst)
    err_pulse_o[0] |-> !($past(ack_i) && !$past(ack_i, 2)));

endmodule

bind hsk_timing_mon hsk_timing_mon_chk u_chk (.*);

// File: tb/tb_hsk_timing_mon.sv
module tb_hsk_timing_mon;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_i = 1'b1;
  logic       ack_i = 1'b0;
  logic [2:0] err_pulse_o, err_sticky_o;
  logic       done_o;

  int   checks = 0;
  int   fails = 0;
  bit   finished = 1'b0;
  logic [2:0] exp_sticky = 3'b000;

  // {stuck_ack, ack_sample(15 = never), high_samples}
  localparam int NCASE = 13;
  localparam logic [9:0] CASES [NCASE] = '{
    {1'b0, 4'd3,  5'd6},  {1'b0, 4'd1,  5'd5},  {1'b0, 4'd10, 5'd11},
    {1'b0, 4'd11, 5'd6},  {1'b0, 4'd15, 5'd4},  {1'b0, 4'd0,  5'd6},
    {1'b1, 4'd15, 5'd6},  {1'b0, 4'd2,  5'd8},  {1'b0, 4'd1,  5'd13},
    {1'b0, 4'd6,  5'd6},  {1'b0, 4'd7,  5'd5},  {1'b0, 4'd2,  5'd3},
    {1'b0, 4'd1,  5'd11}
  };

  always #2 clk = ~clk;

  hsk_timing_mon dut (
    .clk          (clk),
    .rst          (rst),
    .req_i        (req_i),
    .ack_i        (ack_i),
    .err_pulse_o  (err_pulse_o),
    .err_sticky_o (err_sticky_o),
    .done_o       (done_o)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic cyc(input logic r, input logic a);
    @(negedge clk);
    req_i = r;
    ack_i = a;
    @(posedge clk);
    #1;
  endtask

  task automatic run_case(input int A, input int H, input bit stuck,
                          input int pre, input string tag);
    bit   ackok;
    int   hold_res, ack_res, done_s, last_ack;
    logic [2:0] ep;
    ackok    = !stuck && A >= 1 && A <= 10;
    hold_res = (H >= 8) ? 7 : H;
    if (!ackok)         ack_res = 10;
    else if (A >= H)    ack_res = A;
    else if (H - A > 10) ack_res = A + 10;
    else                ack_res = H;
    done_s = H;
    if (hold_res > done_s) done_s = hold_res;
    if (ack_res > done_s)  done_s = ack_res;
    last_ack = (A > H) ? A : H;
    for (int p = 0; p < pre; p++) cyc(1'b0, stuck);
    for (int s = 0; s <= done_s + 2; s++) begin
      cyc(s < H, stuck ? 1'b1 : (A <= 14 && s >= A && s <= last_ack));
      ep[0] = !ackok && s == 10;
      ep[1] = (H < 5 && s == H) || (H >= 8 && s == 7);
      ep[2] = ackok && ((A >= H && s == A) || (A < H && H - A > 10 && s == A + 10));
      exp_sticky = exp_sticky | ep;
      chk(err_pulse_o == ep, tag, $sformatf("pulses A=%0d H=%0d s=%0d", A, H, s),
          err_pulse_o, ep);
      chk(done_o == (s == done_s), "R8", $sformatf("done A=%0d H=%0d s=%0d", A, H, s),
          done_o, s == done_s);
    end
    chk(err_sticky_o == exp_sticky, "R7", "sticky after case", err_sticky_o, exp_sticky);
  endtask

  initial begin
    // R10: reset with request held high
    repeat (3) @(posedge clk);
    #1;
    chk(err_pulse_o == 3'b000 && done_o == 1'b0 && err_sticky_o == 3'b000,
        "R10", "outputs in reset", {err_sticky_o, err_pulse_o, done_o}, 0);
    rst = 1'b0;
    run_case(3, 6, 1'b0, 0, "R10");

    // R1..R6 table walk
    for (int i = 0; i < NCASE; i++)
      run_case(int'(CASES[i][8:5]), int'(CASES[i][4:0]), CASES[i][9], 2,
               "R1,R2,R3,R4,R5,R6");

    // R9: second rise during an open transaction is ignored
    for (int p = 0; p < 2; p++) cyc(1'b0, 1'b0);
    for (int s = 0; s <= 22; s++) begin
      cyc((s < 6) || (s >= 7 && s < 20), 1'b0);
      chk(err_pulse_o == ((s == 10) ? 3'b001 : 3'b000), "R9",
          $sformatf("pulses s=%0d", s), err_pulse_o, (s == 10) ? 1 : 0);
      chk(done_o == (s == 10), "R9", $sformatf("done s=%0d", s), done_o, s == 10);
    end

    // R7: only reset clears sticky bits
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    chk(err_sticky_o == 3'b000, "R7", "sticky after reset", err_sticky_o, 0);
    rst = 1'b0;
    exp_sticky = 3'b000;
    run_case(4, 6, 1'b0, 2, "R7");

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog all-requirements actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule